// File: doc/BRIEF.md
# ADC Offset and Gain Correction Stage

This block sits after the decimation and averaging filter of a sigma-delta converter and turns its raw fractional samples into the 16-bit words that software reads. A full-scale analog input leaves the filter at only about ±0.75 of fractional span, because the modulator keeps some headroom for overrange. The correction stage works in three steps:

- It removes a programmable offset.
- It rescales by a programmable unsigned gain so that full scale becomes ±1.0.
- On the current channel at the highest amplifier setting, it applies a further factor of eight.

The result is clamped, flagged and presented either as a signed or as an offset-binary word.

The offset and gain coefficients live in a small register pair inside the block. A calibration routine overwrites that pair through a one-cycle write strobe. The samples arrive with a valid qualifier, and each one leaves three cycles later with its own valid pulse and saturation flags.

Top module: `adc_gain_offset_corr`

## Requirements
- R1: With unity channel factor, the signed result before clamping is ((S − O·256) · G) / 2^22, truncated toward zero. S is the 24-bit signed sample, O the 16-bit signed offset coefficient and G the 16-bit unsigned gain coefficient. A positive O therefore lowers the result, and O = 0 leaves the sample unchanged.
- R2: After reset, out_valid is 0, out_data is 0x0000 and both flags are 0. The offset coefficient resets to 0x0000 and the gain coefficient to 0x5555, so a sample of +0.75 (0x600000) yields 0x7FFF.
- R3: When chan_cur = 1 and pga_sel = 2'b10 (gain 512), the product is multiplied by 8 before truncation. For pga_sel values 2'b00 (gain 4), 2'b01 (gain 32) and 2'b11, and for any pga_sel with chan_cur = 0, the factor is 1.
- R4: A result above 32767 gives out_ovf = 1 and a two's complement word of 0x7FFF.
- R5: A result below −32768 gives out_unf = 1 and a two's complement word of 0x8000. out_ovf and out_unf are never both 1.
- R6: With unipolar = 1 the word is the two's complement word plus 0x8000, taken modulo 2^16. The clamp bounds then become 0xFFFF and 0x0000, and the flags are unchanged.
- R7: Each cycle with in_valid = 1 produces exactly one out_valid pulse, three cycles later. Back-to-back samples give back-to-back results in order.
- R8: out_data, out_ovf and out_unf hold their last values in every cycle where out_valid is 0.
- R9: A coefficient write with coef_wr = 1 changes the coefficients from the next cycle on. A sample presented in the same cycle as the write is still corrected with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| coef_wr | input | 1 | Write strobe for both coefficients |
| coef_offset_wr | input | 16 | New signed offset coefficient |
| coef_gain_wr | input | 16 | New unsigned gain coefficient (Q2.14) |
| in_valid | input | 1 | Sample qualifier |
| in_sample | input | 24 | Signed fractional filter output |
| chan_cur | input | 1 | 1 selects the current channel |
| pga_sel | input | 2 | Amplifier gain code: 00 = 4, 01 = 32, 10 = 512 |
| unipolar | input | 1 | 1 selects offset-binary output |
| out_valid | output | 1 | Result qualifier |
| out_data | output | 16 | Corrected and clamped result |
| out_ovf | output | 1 | Result was clamped at the positive bound |
| out_unf | output | 1 | Result was clamped at the negative bound |

## Verification
Every cycle, the assertions check the following:

- The valid pulse keeps its three-cycle spacing.
- The two saturation flags are mutually exclusive.
- A raised flag comes only with a bound word.
- The output holds while no result is presented.

The arithmetic itself can only be shown by the bench scenarios. These cover the offset sign and alignment, truncation toward zero on negative products, and the choice of the channel factor. They also cover the exact cycle in which a written coefficient starts to apply, and unipolar formatting at both clamp bounds. The bench compares each of these against a behavioural model on every clock.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  localparam int SAMPLE_W   = 24;
  localparam int COEF_W     = 16;
  localparam int RESULT_W   = 16;
  localparam int GAIN_FRAC  = 14;
  localparam int KSH_MAX    = 3;
  localparam int KSH_W      = 2;

  typedef enum logic [1:0] {
    PGA_X4   = 2'b00,
    PGA_X32  = 2'b01,
    PGA_X512 = 2'b10,
    PGA_RSV  = 2'b11
  } pga_code_e;
endpackage

// File: rtl/adc_corr_coef.sv
module adc_corr_coef #(
  parameter int               CW       = 16,
  parameter logic [CW-1:0]    OFF_RST  = '0,
  parameter logic [CW-1:0]    GAIN_RST = 16'h5555
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_offset,
  input  logic [CW-1:0] wr_gain,
  output logic [CW-1:0] offset_q,
  output logic [CW-1:0] gain_q
);
  logic [CW-1:0] offset_d, gain_d;

  always_comb begin
    offset_d = wr_offset;
    gain_d   = wr_gain;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= OFF_RST;
      gain_q   <= GAIN_RST;
    end else if (wr_en) begin
      offset_q <= offset_d;
      gain_q   <= gain_d;
    end
  end
endmodule

// File: rtl/adc_corr_offset.sv
module adc_corr_offset #(
  parameter int IN_W   = 24,
  parameter int CW     = 16,
  parameter int DIFF_W = 25,
  parameter int KSH_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [IN_W-1:0]          in_sample,
  input  logic [CW-1:0]            offset,
  input  logic [CW-1:0]            gain,
  input  logic [KSH_W-1:0]         ksh,
  input  logic                     uni,
  output logic                     v_q,
  output logic signed [DIFF_W-1:0] diff_q,
  output logic [CW-1:0]            gain_q,
  output logic [KSH_W-1:0]         ksh_q,
  output logic                     uni_q
);
  localparam int ALIGN = IN_W - CW;

  logic signed [DIFF_W-1:0] samp_ext, off_ext, diff_d;

  always_comb begin
    samp_ext = DIFF_W'($signed(in_sample));
    off_ext  = DIFF_W'($signed(offset)) <<< ALIGN;
    diff_d   = samp_ext - off_ext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      diff_q <= '0;
      gain_q <= '0;
      ksh_q  <= '0;
      uni_q  <= 1'b0;
    end else begin
      v_q <= in_valid;
      if (in_valid) begin
        diff_q <= diff_d;
        gain_q <= gain;
        ksh_q  <= ksh;
        uni_q  <= uni;
      end
    end
  end
endmodule

// File: rtl/adc_corr_scale.sv
module adc_corr_scale #(
  parameter int DIFF_W = 25,
  parameter int CW     = 16,
  parameter int KSH_W  = 2,
  parameter int SH     = 22,
  parameter int PROD_W = 45,
  parameter int RES_W  = 23
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_in,
  input  logic signed [DIFF_W-1:0] diff,
  input  logic [CW-1:0]            gain,
  input  logic [KSH_W-1:0]         ksh,
  input  logic                     uni_in,
  output logic                     v_q,
  output logic signed [RES_W-1:0]  res_q,
  output logic                     uni_q
);
  logic signed [PROD_W-1:0] prod, shl;
  logic signed [RES_W-1:0]  res_d;
  logic                     round_up;

  always_comb begin
    prod     = diff * $signed({1'b0, gain});
    shl      = prod <<< ksh;
    // truncation toward zero: a negative value with dropped bits moves up by one
    round_up = shl[PROD_W-1] & (|shl[SH-1:0]);
    res_d    = $signed(shl[PROD_W-1:SH]) + $signed({{(RES_W-1){1'b0}}, round_up});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      res_q <= '0;
      uni_q <= 1'b0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        res_q <= res_d;
        uni_q <= uni_in;
      end
    end
  end
endmodule

// File: rtl/adc_corr_format.sv
module adc_corr_format #(
  parameter int RES_W = 23,
  parameter int OW    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_in,
  input  logic signed [RES_W-1:0] res,
  input  logic                    uni,
  output logic                    v_q,
  output logic [OW-1:0]           data_q,
  output logic                    ovf_q,
  output logic                    unf_q
);
  localparam logic [OW-1:0] POS_BOUND = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] NEG_BOUND = {1'b1, {(OW-1){1'b0}}};

  logic          sgn, ovf_d, unf_d;
  logic [OW-1:0] tc, data_d;

  always_comb begin
    sgn   = res[RES_W-1];
    ovf_d = ~sgn & (|res[RES_W-2:OW-1]);
    unf_d =  sgn & ~(&res[RES_W-2:OW-1]);
    if (ovf_d)      tc = POS_BOUND;
    else if (unf_d) tc = NEG_BOUND;
    else            tc = res[OW-1:0];
    data_d = uni ? {~tc[OW-1], tc[OW-2:0]} : tc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      data_q <= '0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      v_q <= v_in;
      if (v_in) begin
        data_q <= data_d;
        ovf_q  <= ovf_d;
        unf_q  <= unf_d;
      end
    end
  end
endmodule

// File: rtl/adc_gain_offset_corr.sv
module adc_gain_offset_corr
  import adc_corr_pkg::*;
#(
  parameter int            IN_W      = SAMPLE_W,
  parameter int            CW        = COEF_W,
  parameter int            OW        = RESULT_W,
  parameter int            GFRAC     = GAIN_FRAC,
  parameter int            SYNC_LEN  = 2,
  parameter logic [CW-1:0] GAIN_INIT = 16'h5555
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            coef_wr,
  input  logic [CW-1:0]   coef_offset_wr,
  input  logic [CW-1:0]   coef_gain_wr,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_sample,
  input  logic            chan_cur,
  input  logic [1:0]      pga_sel,
  input  logic            unipolar,
  output logic            out_valid,
  output logic [OW-1:0]   out_data,
  output logic            out_ovf,
  output logic            out_unf
);
  localparam int DIFF_W = IN_W + 1;
  localparam int SH     = GFRAC + IN_W - OW;
  localparam int PROD_W = DIFF_W + CW + 1 + KSH_MAX;
  localparam int RES_W  = PROD_W - SH;

  // reset: asserted at once, released through a short synchronizer
  logic [SYNC_LEN-1:0] sync_q;
  logic                rst_sync_n;

  generate
    if (SYNC_LEN == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_LEN-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_sync_n = sync_q[SYNC_LEN-1];

  logic [CW-1:0]    off_cur, gain_cur;
  logic [KSH_W-1:0] ksh;

  always_comb begin
    ksh = (chan_cur && pga_sel == PGA_X512) ? KSH_W'(KSH_MAX) : '0;
  end

  adc_corr_coef #(.CW(CW), .OFF_RST('0), .GAIN_RST(GAIN_INIT)) u_coef (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(coef_wr),
    .wr_offset(coef_offset_wr), .wr_gain(coef_gain_wr),
    .offset_q(off_cur), .gain_q(gain_cur)
  );

  logic                     s1_v, s1_uni;
  logic signed [DIFF_W-1:0] s1_diff;
  logic [CW-1:0]            s1_gain;
  logic [KSH_W-1:0]         s1_ksh;

  adc_corr_offset #(.IN_W(IN_W), .CW(CW), .DIFF_W(DIFF_W), .KSH_W(KSH_W)) u_off (
    .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .in_sample(in_sample),
    .offset(off_cur), .gain(gain_cur), .ksh(ksh), .uni(unipolar),
    .v_q(s1_v), .diff_q(s1_diff), .gain_q(s1_gain), .ksh_q(s1_ksh), .uni_q(s1_uni)
  );

  logic                    s2_v, s2_uni;
  logic signed [RES_W-1:0] s2_res;

  adc_corr_scale #(.DIFF_W(DIFF_W), .CW(CW), .KSH_W(KSH_W), .SH(SH),
                   .PROD_W(PROD_W), .RES_W(RES_W)) u_scl (
    .clk(clk), .rst_n(rst_sync_n), .v_in(s1_v), .diff(s1_diff), .gain(s1_gain),
    .ksh(s1_ksh), .uni_in(s1_uni), .v_q(s2_v), .res_q(s2_res), .uni_q(s2_uni)
  );

  adc_corr_format #(.RES_W(RES_W), .OW(OW)) u_fmt (
    .clk(clk), .rst_n(rst_sync_n), .v_in(s2_v), .res(s2_res), .uni(s2_uni),
    .v_q(out_valid), .data_q(out_data), .ovf_q(out_ovf), .unf_q(out_unf)
  );
endmodule

// File: rtl/adc_corr_chk.sv
module adc_corr_chk #(
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic [OW-1:0] out_data,
  input logic          out_ovf,
  input logic          out_unf
);
  localparam logic [OW-1:0] TC_MAX = {1'b0, {(OW-1){1'b1}}};
  localparam logic [OW-1:0] TC_MIN = {1'b1, {(OW-1){1'b0}}};
  localparam logic [OW-1:0] UP_MAX = {OW{1'b1}};
  localparam logic [OW-1:0] UP_MIN = {OW{1'b0}};

  logic [1:0] warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R7
  latency_three_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R5
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_ovf && out_unf));

  // R4
  ovf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_data == TC_MAX || out_data == UP_MAX));

  // R5
  unf_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unf) |-> (out_data == TC_MIN || out_data == UP_MIN));

  // R8
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm != 2'd0 && !out_valid) |-> ($stable(out_data) && $stable(out_ovf) && $stable(out_unf)));
endmodule

bind adc_gain_offset_corr adc_corr_chk #(.OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_data(out_data), .out_ovf(out_ovf), .out_unf(out_unf)
);

// File: tb/tb_adc_gain_offset_corr.sv
module tb_adc_gain_offset_corr;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        coef_wr;
  logic [15:0] coef_offset_wr, coef_gain_wr;
  logic        in_valid;
  logic [23:0] in_sample;
  logic        chan_cur;
  logic [1:0]  pga_sel;
  logic        unipolar;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ovf, out_unf;

  adc_gain_offset_corr dut (
    .clk(clk), .rst_n(rst_n), .coef_wr(coef_wr), .coef_offset_wr(coef_offset_wr),
    .coef_gain_wr(coef_gain_wr), .in_valid(in_valid), .in_sample(in_sample),
    .chan_cur(chan_cur), .pga_sel(pga_sel), .unipolar(unipolar),
    .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf), .out_unf(out_unf)
  );

  typedef struct {
    longint      due;
    logic [15:0] d;
    logic        ov;
    logic        un;
    string       req;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  longint      cyc = 0;
  bit          run = 0;
  logic [15:0] m_off, m_gain;
  logic [15:0] last_d;
  logic        last_ov, last_un;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [23:0] s, input logic [15:0] off,
                                 input logic [15:0] g, input bit cur,
                                 input logic [1:0] pga, input bit uni, input string req);
    exp_t   e;
    longint diff, p, r;
    logic [15:0] w;
    diff = longint'($signed(s)) - longint'($signed(off)) * 256;
    p    = diff * longint'(g);
    if (cur && pga == 2'b10) p = p * 8;
    r    = p / 64'sd4194304;
    e.ov = (r > 32767);
    e.un = (r < -32768);
    if (e.ov)      w = 16'h7FFF;
    else if (e.un) w = 16'h8000;
    else           w = r[15:0];
    e.d   = uni ? (w ^ 16'h8000) : w;
    e.req = req;
    e.due = 0;
    return e;
  endfunction

  always @(negedge clk) begin
    if (run) begin
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        chk(out_valid === 1'b1, "R7", "out_valid", out_valid, 1);
        chk(out_data === e.d, e.req, "out_data", out_data, e.d);
        chk(out_ovf === e.ov, e.req, "out_ovf", out_ovf, e.ov);
        chk(out_unf === e.un, e.req, "out_unf", out_unf, e.un);
        last_d = e.d; last_ov = e.ov; last_un = e.un;
      end else begin
        chk(out_valid === 1'b0, "R7", "out_valid idle", out_valid, 0);
        chk(out_data === last_d && out_ovf === last_ov && out_unf === last_un,
            "R8", "held output", out_data, last_d);
      end
    end
  end

  task automatic step(input bit v, input logic [23:0] s, input bit cur,
                      input logic [1:0] pga, input bit uni, input bit wr,
                      input logic [15:0] woff, input logic [15:0] wgain, input string req);
    @(negedge clk);
    in_valid = v; in_sample = s; chan_cur = cur; pga_sel = pga; unipolar = uni;
    coef_wr = wr; coef_offset_wr = woff; coef_gain_wr = wgain;
    if (v) begin
      exp_t e;
      e = model(s, m_off, m_gain, cur, pga, uni, req);
      e.due = cyc + 3;
      q.push_back(e);
    end
    if (wr) begin
      m_off = woff; m_gain = wgain;
    end
  endtask

  task automatic smp(input logic [23:0] s, input bit cur, input logic [1:0] pga,
                     input bit uni, input string req);
    step(1'b1, s, cur, pga, uni, 1'b0, 16'h0, 16'h0, req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 24'h0, 1'b0, 2'b00, 1'b0, 1'b0, 16'h0, 16'h0, "R8");
  endtask

  task automatic wcoef(input logic [15:0] o, input logic [15:0] g);
    step(1'b0, 24'h0, 1'b0, 2'b00, 1'b0, 1'b1, o, g, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", q.size());
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; coef_wr = 1'b0; coef_offset_wr = '0; coef_gain_wr = '0;
    in_valid = 1'b0; in_sample = '0; chan_cur = 1'b0; pga_sel = 2'b00; unipolar = 1'b0;
    m_off = 16'h0000; m_gain = 16'h5555;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(out_valid === 1'b0, "R2", "reset out_valid", out_valid, 0);
    chk(out_data === 16'h0000, "R2", "reset out_data", out_data, 0);
    chk(out_ovf === 1'b0 && out_unf === 1'b0, "R2", "reset flags", {out_ovf, out_unf}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    last_d = 16'h0000; last_ov = 1'b0; last_un = 1'b0;
    run = 1;

    // R2: reset coefficients map +/-0.75 to full scale
    smp(24'h600000, 0, 2'b00, 0, "R2");
    smp(24'hA00000, 0, 2'b00, 0, "R2");
    smp(24'h000000, 0, 2'b00, 0, "R2");
    idle(4);

    // R1: offset subtraction and alignment, truncation toward zero
    wcoef(16'h0100, 16'h4000);
    smp(24'h100000, 0, 2'b00, 0, "R1");
    smp(24'hF00000, 0, 2'b00, 0, "R1");
    wcoef(16'hFF00, 16'h5555);
    smp(24'h123456, 0, 2'b01, 0, "R1");
    smp(24'hFEDCBB, 0, 2'b00, 0, "R1");
    smp(24'hFFFFFF, 0, 2'b00, 0, "R1");
    idle(4);

    // R3: channel factor
    wcoef(16'h0000, 16'h4000);
    smp(24'h0F0000, 1, 2'b10, 0, "R3");
    smp(24'h0F0000, 1, 2'b00, 0, "R3");
    smp(24'h0F0000, 1, 2'b01, 0, "R3");
    smp(24'h0F0000, 1, 2'b11, 0, "R3");
    smp(24'h0F0000, 0, 2'b10, 0, "R3");
    smp(24'hF1F000, 1, 2'b10, 0, "R3");
    idle(4);

    // R4 / R5: clamping in two's complement
    smp(24'h100000, 1, 2'b10, 0, "R4");
    wcoef(16'h0000, 16'hFFFF);
    smp(24'h7FFFFF, 0, 2'b00, 0, "R4");
    smp(24'h800000, 0, 2'b00, 0, "R5");
    wcoef(16'h7FFF, 16'h5555);
    smp(24'h800000, 0, 2'b00, 0, "R5");
    idle(4);

    // R6: unipolar formatting and its bounds
    wcoef(16'h0000, 16'h4000);
    smp(24'h000000, 0, 2'b00, 1, "R6");
    smp(24'h345678, 0, 2'b00, 1, "R6");
    smp(24'hC00000, 0, 2'b00, 1, "R6");
    smp(24'h100000, 1, 2'b10, 1, "R6");
    smp(24'hF00000, 1, 2'b10, 1, "R6");
    idle(4);

    // R7 / R8: streaming with gaps
    for (int i = 0; i < 20; i++) begin
      if (i % 5 == 3) idle(i % 3);
      smp(24'(i * 24'h05A3C1), i[0], 2'(i), i[2], "R7");
    end
    idle(5);

    // R9: write and sample in the same cycle, then the next sample
    step(1'b1, 24'h200000, 0, 2'b00, 0, 1'b1, 16'h1000, 16'h2000, "R9");
    smp(24'h200000, 0, 2'b00, 0, "R9");
    idle(5);

    chk(q.size() == 0, "R7", "pending results", q.size(), 0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule